// File: doc/BRIEF.md
# Shared-Slot Bulk Serial Transmitter

This block turns a stream of bytes into a serial bit stream on one data line. The line is shared with an audio codec. Everything runs on the rising edge of an external bit clock, and the receiver samples the line on the falling edge. Bytes arrive over a valid/ready handshake and leave most significant bit first. An enable strobe marks each contiguous burst of bits.

When audio is present, each left-channel frame-sync pulse reserves the line for the codec for a fixed number of bit clocks. The data line is released during that time, and the transmitter resumes afterwards at the next unsent bit. A FIFO-full flag from the receiver pauses the transmission in the same lossless way.

Both outputs are modelled as a value plus a drive enable. A drive enable of 0 means high impedance. When the block is disabled or idle, it releases the data line. When the block is disabled, it also releases the strobe.

Top module: `bulk_tx`

## Requirements
- R1: While reset is asserted, and after it is released with the output mode bit off, `dout_oe` and `strobe_oe` are 0.
- R2: A byte accepted at a rising edge (`byte_valid` and `byte_ready` both 1) starts on `dout` right after that edge. Its bits follow one per bit clock, bit 7 first and bit 0 last.
- R3: `strobe` is 1 in exactly the cycles in which `dout_oe` is 1. Back-to-back bytes form one unbroken burst. `strobe` returns to 0 in the cycle after bit 0 of the last byte available.
- R4: When `fifo_full` is sampled 1, the next cycle has `dout_oe` = 0 and `strobe` = 0, and no bit is consumed. Once `fifo_full` returns to 0, sending resumes at the next unsent bit, with no bit lost or repeated.
- R5: With `audio_on` = 1 and `stereo` = 0, a frame-sync edge keeps `dout_oe` at 0 for that cycle and the following 16 cycles (17 quiet cycles). The first bit appears in the 18th cycle.
- R6: With `audio_on` = 1 and `stereo` = 1, the quiet span after frame sync is 33 cycles.
- R7: Every frame-sync pulse re-arms the quiet span, including one that arrives in the middle of a byte. The byte then continues at its next unsent bit after the span.
- R8: With `audio_on` = 0, `frame_sync` has no effect: a byte in progress keeps its bit on `dout` in the cycle after the pulse.
- R9: With `out_en_mode` = 0, `dout_oe` and `strobe_oe` are 0, `byte_ready` is 0 and no bytes are consumed. With `out_en_mode` = 1, `strobe_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock; data changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_data | input | BW | Byte offered by the source |
| byte_valid | input | 1 | Source has a byte |
| byte_ready | output | 1 | Byte is taken at this edge |
| frame_sync | input | 1 | Left-channel frame-sync pulse |
| fifo_full | input | 1 | Receiver FIFO full, pause sending |
| out_en_mode | input | 1 | Enable driving of both outputs |
| audio_on | input | 1 | Audio shares the line, honour the slot |
| stereo | input | 1 | Audio slot is 32 clocks instead of 16 |
| dout | output | 1 | Serial data value |
| dout_oe | output | 1 | Drive enable for dout (0 = high impedance) |
| strobe | output | 1 | Burst enable strobe |
| strobe_oe | output | 1 | Drive enable for strobe (0 = high impedance) |

## Verification
The bench targets the resume points. These are a FIFO-full pause three bits into a byte and a frame sync arriving in the middle of a byte. A design that dropped or repeated a bit there would produce a captured bit stream that no longer matches the queued bytes.

The audio-slot length is measured in quiet cycles for both mono and stereo. An off-by-one in the slot counter would show up as 16 or 18 quiet cycles, or 32 or 34.

The bench also checks that a disabled transmitter consumes no bytes, and that back-to-back bytes keep the strobe high as one burst. A design that let `byte_ready` rise while disabled would lose a byte. One that gapped between bytes would split the strobe.

// File: rtl/bulk_tx_pkg.sv
package bulk_tx_pkg;

  // Drive state of the two shared pins: a value and an enable for each.
  typedef struct packed {
    logic dat;
    logic dat_oe;
    logic stb;
    logic stb_oe;
  } line_drive_t;

  localparam line_drive_t LINE_IDLE = '{dat: 1'b0, dat_oe: 1'b0, stb: 1'b0, stb_oe: 1'b0};

endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
  parameter int MONO_SLOT   = 16,
  parameter int STEREO_SLOT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic audio_on,
  input  logic stereo,
  input  logic frame_sync,
  output logic window_open
);
  localparam int CW = $clog2(STEREO_SLOT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = frame_sync | (cnt_q != '0);
    if (frame_sync) cnt_d = stereo ? CW'(STEREO_SLOT) : CW'(MONO_SLOT);
    else            cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign window_open = !audio_on || (!frame_sync && (cnt_q == '0));

  AST_SLOT_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    frame_sync |=> (cnt_q != '0)); // R7

endmodule

// File: rtl/bit_shifter.sv
module bit_shifter #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          can_send,
  input  logic [BW-1:0] byte_data,
  input  logic          byte_valid,
  output logic          byte_ready,
  output logic          send_now,
  output logic          send_bit
);
  localparam int LW = $clog2(BW);

  logic          hold_q, hold_d;
  logic [BW-2:0] sh_q, sh_d;
  logic [LW-1:0] left_q, left_d;

  always_comb begin
    byte_ready = can_send & ~hold_q;
    send_now   = can_send & (hold_q | byte_valid);
    if (hold_q) begin
      send_bit = sh_q[BW-2];
      sh_d     = sh_q << 1;
      left_d   = left_q - 1'b1;
      hold_d   = (left_q != LW'(1));
    end else begin
      send_bit = byte_data[BW-1];
      sh_d     = byte_data[BW-2:0];
      left_d   = LW'(BW - 1);
      hold_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= 1'b0;
      sh_q   <= '0;
      left_q <= '0;
    end else if (send_now) begin
      hold_q <= hold_d;
      sh_q   <= sh_d;
      left_q <= left_d;
    end
  end

  AST_PAUSE_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !can_send) |=> (hold_q && $stable(left_q))); // R4

endmodule

// File: rtl/out_stage.sv
module out_stage
  import bulk_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        send_now,
  input  logic        send_bit,
  input  logic        mode_en,
  output line_drive_t drv_q
);
  line_drive_t drv_d;

  always_comb begin
    drv_d.dat    = send_now & send_bit;
    drv_d.dat_oe = send_now;
    drv_d.stb    = send_now;
    drv_d.stb_oe = mode_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drv_q <= LINE_IDLE;
    else        drv_q <= drv_d;
  end

  AST_STROBE_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    drv_q.dat_oe |-> (drv_q.stb && drv_q.stb_oe)); // R3

endmodule

// File: rtl/bulk_tx.sv
module bulk_tx
  import bulk_tx_pkg::*;
#(
  parameter int BW          = 8,
  parameter int MONO_SLOT   = 16,
  parameter int STEREO_SLOT = 32
) (
  input  logic          bit_clk,
  input  logic          rst_n,
  input  logic [BW-1:0] byte_data,
  input  logic          byte_valid,
  output logic          byte_ready,
  input  logic          frame_sync,
  input  logic          fifo_full,
  input  logic          out_en_mode,
  input  logic          audio_on,
  input  logic          stereo,
  output logic          dout,
  output logic          dout_oe,
  output logic          strobe,
  output logic          strobe_oe
);
  // Asynchronous assert, synchronous release.
  logic [1:0] rs_q;
  logic       rst_int;

  always_ff @(posedge bit_clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_int = rs_q[1];

  logic        window_open, can_send, send_now, send_bit;
  line_drive_t drv;

  slot_timer #(.MONO_SLOT(MONO_SLOT), .STEREO_SLOT(STEREO_SLOT)) u_slot (
    .clk(bit_clk), .rst_n(rst_int), .audio_on(audio_on), .stereo(stereo),
    .frame_sync(frame_sync), .window_open(window_open));

  assign can_send = out_en_mode & ~fifo_full & window_open;

  bit_shifter #(.BW(BW)) u_shift (
    .clk(bit_clk), .rst_n(rst_int), .can_send(can_send), .byte_data(byte_data),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .send_now(send_now),
    .send_bit(send_bit));

  out_stage u_out (
    .clk(bit_clk), .rst_n(rst_int), .send_now(send_now), .send_bit(send_bit),
    .mode_en(out_en_mode), .drv_q(drv));

  assign dout      = drv.dat;
  assign dout_oe   = drv.dat_oe;
  assign strobe    = drv.stb;
  assign strobe_oe = drv.stb_oe;

  AST_MSB_FIRST: assert property (@(posedge bit_clk) disable iff (!rst_int)
    (byte_valid && byte_ready) |=> (dout_oe && (dout == $past(byte_data[BW-1])))); // R2
  AST_FULL_PAUSE: assert property (@(posedge bit_clk) disable iff (!rst_int)
    fifo_full |=> (!dout_oe && !strobe)); // R4
  AST_SLOT_QUIET: assert property (@(posedge bit_clk) disable iff (!rst_int)
    (audio_on && frame_sync) |=> !dout_oe); // R5
  AST_OFF_RELEASE: assert property (@(posedge bit_clk) disable iff (!rst_int)
    !out_en_mode |=> (!dout_oe && !strobe_oe && !strobe)); // R9

endmodule

// File: tb/tb_bulk_tx.sv
`timescale 1ns/1ps
module tb_bulk_tx;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] byte_data;
  logic       byte_valid, byte_ready;
  logic       frame_sync, fifo_full, out_en_mode, audio_on, stereo;
  logic       dout, dout_oe, strobe, strobe_oe;

  always #4 clk = ~clk;

  bulk_tx dut (
    .bit_clk(clk), .rst_n(rst_n), .byte_data(byte_data), .byte_valid(byte_valid),
    .byte_ready(byte_ready), .frame_sync(frame_sync), .fifo_full(fifo_full),
    .out_en_mode(out_en_mode), .audio_on(audio_on), .stereo(stereo),
    .dout(dout), .dout_oe(dout_oe), .strobe(strobe), .strobe_oe(strobe_oe));

  localparam logic [7:0] VEC [0:7] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h80, 8'h01, 8'h3C, 8'hC3};

  int         nchk = 0, nfail = 0;
  logic [7:0] src_mem [0:63];
  int         src_cnt, src_idx;
  logic       cap [0:1023];
  int         cap_n, runs, q;
  logic       prev_stb;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    logic r, v;
    #1;
    r = byte_ready;
    v = byte_valid;
    @(posedge clk);
    @(negedge clk);
    if (r && v) src_idx++;
    byte_valid = (src_idx < src_cnt);
    byte_data  = src_mem[src_idx];
    if (dout_oe) begin
      cap[cap_n] = dout;
      cap_n++;
    end
    if (prev_stb && !strobe) runs++;
    prev_stb = strobe;
  endtask

  task automatic push(input logic [7:0] b);
    src_mem[src_cnt] = b;
    src_cnt++;
    byte_valid = 1'b1;
    byte_data  = src_mem[src_idx];
  endtask

  task automatic clear();
    src_cnt = 0; src_idx = 0; cap_n = 0; runs = 0;
    byte_valid = 1'b0;
  endtask

  function automatic bit stream_ok();
    if (cap_n != 8 * src_cnt) return 1'b0;
    for (int i = 0; i < cap_n; i++)
      if (cap[i] !== src_mem[i/8][7 - (i % 8)]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic count_quiet();
    q = 0;
    while (!dout_oe && q < 100) begin
      q++;
      tick();
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; byte_data = '0; byte_valid = 1'b0; frame_sync = 1'b0;
    fifo_full = 1'b0; out_en_mode = 1'b0; audio_on = 1'b0; stereo = 1'b0;
    prev_stb = 1'b0;
    clear();
    repeat (3) @(negedge clk);
    check(!dout_oe && !strobe_oe, "R1 in reset", {dout_oe, strobe_oe}, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    check(!dout_oe && !strobe_oe, "R1 after release", {dout_oe, strobe_oe}, 0);
    out_en_mode = 1'b1;
    tick();

    // R2 vector table: one byte each, MSB first, strobe ends after LSB (R3)
    for (int i = 0; i < 8; i++) begin
      clear(); runs = 0;
      push(VEC[i]);
      repeat (12) tick();
      check(stream_ok(), "R2 msb-first bits", cap_n, 8);
      check(runs == 1 && !strobe, "R3 single burst", runs, 1);
    end

    // R3 back-to-back bytes stay one burst
    clear();
    push(8'h12); push(8'hE7); push(8'h69);
    repeat (30) tick();
    check(stream_ok(), "R3 back-to-back stream", cap_n, 24);
    check(runs == 1, "R3 unbroken strobe", runs, 1);

    // R4 FIFO-full pause mid-byte
    clear();
    push(8'hB4); push(8'h2D);
    repeat (3) tick();
    fifo_full = 1'b1;
    tick();
    check(!dout_oe && !strobe, "R4 pause releases", {dout_oe, strobe}, 0);
    repeat (4) tick();
    check(cap_n == 3, "R4 no bit while full", cap_n, 3);
    fifo_full = 1'b0;
    repeat (20) tick();
    check(stream_ok(), "R4 resume next bit", cap_n, 16);

    // R9 output disabled
    clear();
    out_en_mode = 1'b0;
    tick();
    push(8'h96);
    repeat (5) tick();
    check(!dout_oe && !strobe_oe, "R9 outputs released", {dout_oe, strobe_oe}, 0);
    check(src_idx == 0, "R9 nothing consumed", src_idx, 0);
    out_en_mode = 1'b1;
    tick();
    check(strobe_oe == 1'b1, "R9 strobe driven", strobe_oe, 1);
    repeat (12) tick();
    check(stream_ok(), "R9 byte sent after enable", cap_n, 8);

    // R5 mono audio slot
    clear();
    audio_on = 1'b1; stereo = 1'b0;
    frame_sync = 1'b1;
    push(8'hC9);
    tick();
    frame_sync = 1'b0;
    count_quiet();
    check(q == 17, "R5 mono quiet cycles", q, 17);
    repeat (12) tick();
    check(stream_ok(), "R5 byte after slot", cap_n, 8);

    // R6 stereo audio slot
    clear();
    stereo = 1'b1;
    frame_sync = 1'b1;
    push(8'h4E);
    tick();
    frame_sync = 1'b0;
    count_quiet();
    check(q == 33, "R6 stereo quiet cycles", q, 33);
    repeat (12) tick();
    check(stream_ok(), "R6 byte after slot", cap_n, 8);

    // R7 frame sync mid-byte re-arms slot
    clear();
    stereo = 1'b0;
    push(8'h71); push(8'h8E);
    repeat (3) tick();
    frame_sync = 1'b1;
    tick();
    frame_sync = 1'b0;
    count_quiet();
    check(q == 17, "R7 re-armed quiet cycles", q, 17);
    repeat (20) tick();
    check(stream_ok(), "R7 resume next bit", cap_n, 16);

    // R8 frame sync ignored without audio
    clear();
    audio_on = 1'b0;
    push(8'hD2); push(8'h3B);
    repeat (3) tick();
    frame_sync = 1'b1;
    tick();
    frame_sync = 1'b0;
    check(dout_oe == 1'b1, "R8 no gap on frame sync", dout_oe, 1);
    repeat (20) tick();
    check(stream_ok() && runs == 1, "R8 stream intact", cap_n, 16);

    finish_run();
  end
endmodule